// File: doc/BRIEF.md
# Timed PPS Command Pulse Generator

This block drives a pulse-per-second style output whose start and stop are scheduled by a small set of host commands. It watches a free-running system time (seconds and nanoseconds, supplied as plain input vectors) and a programmed target time. When an armed event's target time is reached, it begins a single pulse or a repeating pulse train, stops a running train, or raises a one-cycle target-time interrupt. Which of these happen depends on a 2-bit target-mode field.

The host writes a 4-bit command into a command field. The field clears itself on the clock edge after the write, once the scheduler has taken the command. A write that lands while the field still holds a command is dropped and sets a sticky error flag. A pending start or a pending timed stop can be cancelled as long as its target time has not yet been reached. The pulse width and the train half-period come from a width input, counted in clock ticks. All pins are plain control and status levels. The block carries no data stream, so it has no valid/ready handshake and no back-pressure. The host write strobe is taken in a single cycle.

Top module: `pps_cmd_gen`

## Requirements
- R1: The command codes are 1 = single pulse, 2 = pulse train, 3 = cancel start, 4 = stop at target, 5 = stop now and 6 = cancel stop. Code 0 and codes 7 to 15 change neither `pps_out` nor `tgt_irq`.
- R2: A single pulse rises on the first clock edge at which the time has reached the target and the start is armed. It stays high for `pulse_width` cycles. The target counts as reached when the unsigned concatenation {sys_sec, sys_ns} is greater than or equal to {tgt_sec, tgt_ns}.
- R3: A pulse train rises at the same edge as a single pulse would. It then stays high for `pulse_width` cycles and low for `pulse_width` cycles, and repeats until it is stopped.
- R4: A `pulse_width` of 0 behaves as a width of 1.
- R5: Cancel start disarms a pending start only if the target has not been reached at the edge where the command takes effect. Otherwise it has no effect.
- R6: Stop at target arms a stop only while a train runs. The train goes low on the edge where the target is reached. Stop now drives the output low on the edge where the command takes effect. Both stop commands have no effect on a single pulse.
- R7: Cancel stop disarms a pending timed stop if its target has not been reached. The train then keeps running freely.
- R8: A write puts the code into `host_cmd`. The field holds it for one cycle and then returns to 0. The command acts at that second edge.
- R9: A write while `host_cmd` is nonzero is dropped and sets `host_err`. `host_err` stays set until reset.
- R10: `tgt_mode` 2 and 3 let target events drive the output. Modes 0 and 2 raise `tgt_irq` for one cycle, coincident with the event edge. Mode 1 does neither.
- R11: A synchronous active-high `rst` drives the output and the interrupt low, clears the armed start and stop, clears the command field and clears the error flag.
- R12: A start command that takes effect while a pulse or a train is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_sec | input | SEC_W | System time, seconds |
| sys_ns | input | NS_W | System time, nanoseconds |
| tgt_sec | input | SEC_W | Target time, seconds |
| tgt_ns | input | NS_W | Target time, nanoseconds |
| pulse_width | input | WID_W | Pulse width and half-period of the train, in clock ticks |
| tgt_mode | input | 2 | Target-event mode: 0 interrupt only, 1 reserved, 2 interrupt and output, 3 output only |
| host_wr | input | 1 | Host write strobe for the command field |
| host_wdata | input | 4 | Command code written by the host |
| host_cmd | output | 4 | Current content of the command field |
| host_err | output | 1 | Sticky flag for a write that was dropped |
| pps_out | output | 1 | Pulse output |
| tgt_irq | output | 1 | One-cycle target-time interrupt |

## Verification
Single-pulse and train commands are swept over every target mode, widths 0 to 3, several target offsets and two time bases. One of the bases places the target just across a nanosecond rollover. This separates the output gating from the interrupt gating, shows whether the width is counted correctly, and exposes a compare that orders nanoseconds before seconds. Each cancel is tried both before and after its target is reached, so an unconditional cancel is caught as readily as an ignored one. Timed stops are swept over several stop targets and widths, which pins down the exact stop edge inside either phase of the train. Reserved codes, back-to-back writes, a start issued into a running train, stop commands issued into a single pulse and resets during a pending or running train each have a run of their own.

// File: rtl/pps_pkg.sv
package pps_pkg;

  localparam int CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_NONE       = 4'd0,
    CMD_ONE_SHOT   = 4'd1,
    CMD_TRAIN      = 4'd2,
    CMD_DROP_START = 4'd3,
    CMD_STOP_AT    = 4'd4,
    CMD_STOP_NOW   = 4'd5,
    CMD_DROP_STOP  = 4'd6
  } pps_cmd_e;

  // target events may drive the output in modes 2 and 3
  function automatic logic mode_drives_output(input logic [1:0] m);
    return m[1];
  endfunction

  // target events raise the interrupt in modes 0 and 2
  function automatic logic mode_raises_irq(input logic [1:0] m);
    return (m == 2'd0) || (m == 2'd2);
  endfunction

endpackage

// File: rtl/pps_time_cmp.sv
module pps_time_cmp #(
  parameter int SEC_W = 32,
  parameter int NS_W  = 30
) (
  input  logic [SEC_W-1:0] now_sec,
  input  logic [NS_W-1:0]  now_ns,
  input  logic [SEC_W-1:0] due_sec,
  input  logic [NS_W-1:0]  due_ns,
  output logic             reached
);
  localparam int TW = SEC_W + NS_W;

  logic [TW-1:0] now_t;
  logic [TW-1:0] due_t;

  // seconds form the upper part, so one unsigned compare orders both fields
  assign now_t   = {now_sec, now_ns};
  assign due_t   = {due_sec, due_ns};
  assign reached = (now_t >= due_t);
endmodule

// File: rtl/pps_cmd_port.sv
module pps_cmd_port
  import pps_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CMD_W-1:0] wdata,
  output logic [CMD_W-1:0] cmd,
  output logic             err
);
  logic busy;
  assign busy = (cmd != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd <= '0;
      err <= 1'b0;
    end else begin
      if (busy) begin
        cmd <= '0;            // taken by the scheduler this edge
      end else if (wr) begin
        cmd <= wdata;
      end
      if (wr && busy) begin
        err <= 1'b1;          // write dropped
      end
    end
  end
endmodule

// File: rtl/pps_sched.sv
module pps_sched
  import pps_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] cmd,
  input  logic             reached,
  input  logic [1:0]       mode,
  input  logic             busy,
  input  logic             train_on,
  output logic             go_single,
  output logic             go_train,
  output logic             halt,
  output logic             irq,
  output logic             start_armed,
  output logic             stop_armed
);
  logic start_is_train;
  logic start_fire, stop_fire;
  logic out_en, irq_en;
  logic c_single, c_train, c_drop_start, c_stop_at, c_stop_now, c_drop_stop;

  always_comb begin
    c_single     = 1'b0;
    c_train      = 1'b0;
    c_drop_start = 1'b0;
    c_stop_at    = 1'b0;
    c_stop_now   = 1'b0;
    c_drop_stop  = 1'b0;
    case (cmd)
      CMD_ONE_SHOT:   c_single     = 1'b1;
      CMD_TRAIN:      c_train      = 1'b1;
      CMD_DROP_START: c_drop_start = 1'b1;
      CMD_STOP_AT:    c_stop_at    = 1'b1;
      CMD_STOP_NOW:   c_stop_now   = 1'b1;
      CMD_DROP_STOP:  c_drop_stop  = 1'b1;
      default: ;                          // none or reserved
    endcase
  end

  assign out_en     = mode_drives_output(mode);
  assign irq_en     = mode_raises_irq(mode);
  assign start_fire = start_armed & reached;
  assign stop_fire  = stop_armed & reached;

  assign go_single = start_fire & out_en & ~start_is_train;
  assign go_train  = start_fire & out_en & start_is_train;
  assign halt      = (c_stop_now & train_on) | (stop_fire & out_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_armed    <= 1'b0;
      start_is_train <= 1'b0;
      stop_armed     <= 1'b0;
      irq            <= 1'b0;
    end else begin
      irq <= (start_fire | stop_fire) & irq_en;

      if (start_fire) begin
        start_armed <= 1'b0;
      end else if ((c_single | c_train) && !busy) begin
        start_armed    <= 1'b1;
        start_is_train <= c_train;
      end else if (c_drop_start && !reached) begin
        start_armed <= 1'b0;
      end

      if (stop_fire || c_stop_now) begin
        stop_armed <= 1'b0;
      end else if (c_stop_at && train_on) begin
        stop_armed <= 1'b1;
      end else if (c_drop_stop && !reached) begin
        stop_armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pps_wave.sv
module pps_wave #(
  parameter int WID_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_single,
  input  logic             go_train,
  input  logic             halt,
  input  logic [WID_W-1:0] width,
  output logic             pps,
  output logic             single_on,
  output logic             train_on
);
  localparam logic [WID_W-1:0] ONE = WID_W'(1);

  logic [WID_W-1:0] eff_w;
  logic [WID_W-1:0] cnt;     // cycles spent in the current phase
  logic             phase_done;

  assign eff_w      = (width == '0) ? ONE : width;
  assign phase_done = (cnt >= eff_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      pps       <= 1'b0;
      single_on <= 1'b0;
      train_on  <= 1'b0;
      cnt       <= ONE;
    end else if (halt) begin
      pps      <= 1'b0;
      train_on <= 1'b0;
      cnt      <= ONE;
    end else if (go_single) begin
      pps       <= 1'b1;
      single_on <= 1'b1;
      cnt       <= ONE;
    end else if (go_train) begin
      pps      <= 1'b1;
      train_on <= 1'b1;
      cnt      <= ONE;
    end else if (single_on) begin
      if (phase_done) begin
        pps       <= 1'b0;
        single_on <= 1'b0;
        cnt       <= ONE;
      end else begin
        cnt <= cnt + ONE;
      end
    end else if (train_on) begin
      if (phase_done) begin
        pps <= ~pps;
        cnt <= ONE;
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end
endmodule

// File: rtl/pps_cmd_gen.sv
module pps_cmd_gen
  import pps_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int NS_W  = 30,
  parameter int WID_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEC_W-1:0] sys_sec,
  input  logic [NS_W-1:0]  sys_ns,
  input  logic [SEC_W-1:0] tgt_sec,
  input  logic [NS_W-1:0]  tgt_ns,
  input  logic [WID_W-1:0] pulse_width,
  input  logic [1:0]       tgt_mode,
  input  logic             host_wr,
  input  logic [3:0]       host_wdata,
  output logic [3:0]       host_cmd,
  output logic             host_err,
  output logic             pps_out,
  output logic             tgt_irq
);
  logic reached;
  logic go_single, go_train, halt;
  logic start_armed, stop_armed;
  logic single_on, train_on;

  pps_time_cmp #(.SEC_W(SEC_W), .NS_W(NS_W)) u_cmp (
    .now_sec (sys_sec),
    .now_ns  (sys_ns),
    .due_sec (tgt_sec),
    .due_ns  (tgt_ns),
    .reached (reached)
  );

  pps_cmd_port u_port (
    .clk   (clk),
    .rst   (rst),
    .wr    (host_wr),
    .wdata (host_wdata),
    .cmd   (host_cmd),
    .err   (host_err)
  );

  pps_sched u_sched (
    .clk         (clk),
    .rst         (rst),
    .cmd         (host_cmd),
    .reached     (reached),
    .mode        (tgt_mode),
    .busy        (single_on | train_on),
    .train_on    (train_on),
    .go_single   (go_single),
    .go_train    (go_train),
    .halt        (halt),
    .irq         (tgt_irq),
    .start_armed (start_armed),
    .stop_armed  (stop_armed)
  );

  pps_wave #(.WID_W(WID_W)) u_wave (
    .clk       (clk),
    .rst       (rst),
    .go_single (go_single),
    .go_train  (go_train),
    .halt      (halt),
    .width     (pulse_width),
    .pps       (pps_out),
    .single_on (single_on),
    .train_on  (train_on)
  );
endmodule

// File: rtl/pps_cmd_gen_chk.sv
module pps_cmd_gen_chk #(
  parameter int SEC_W = 32,
  parameter int NS_W  = 30
) (
  input logic             clk,
  input logic             rst,
  input logic [SEC_W-1:0] sys_sec,
  input logic [NS_W-1:0]  sys_ns,
  input logic [SEC_W-1:0] tgt_sec,
  input logic [NS_W-1:0]  tgt_ns,
  input logic [1:0]       tgt_mode,
  input logic             host_wr,
  input logic [3:0]       host_cmd,
  input logic             host_err,
  input logic             pps_out,
  input logic             tgt_irq,
  input logic             start_armed,
  input logic             stop_armed,
  input logic             single_on,
  input logic             train_on
);
  // R2: a fresh pulse only starts once the target time was reached
  a_r2_rise_after_target: assert property (@(posedge clk) disable iff (rst)
    ($rose(pps_out) && $past(!single_on && !train_on)) |->
      $past({sys_sec, sys_ns} >= {tgt_sec, tgt_ns}));

  // R10: output starts only in an output-driving mode
  a_r10_out_mode: assert property (@(posedge clk) disable iff (rst)
    ($rose(pps_out) && $past(!single_on && !train_on)) |-> $past(tgt_mode[1]));

  // R10: interrupt only in modes 0 and 2
  a_r10_irq_mode: assert property (@(posedge clk) disable iff (rst)
    tgt_irq |-> $past(!tgt_mode[0]));

  // R8: the command field clears one cycle after it is loaded
  a_r8_self_clear: assert property (@(posedge clk) disable iff (rst)
    (host_cmd != 4'd0) |=> (host_cmd == 4'd0));

  // R9: error flag is sticky and caused by a write into a busy field
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    host_err |=> host_err);
  a_r9_err_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(host_err) |-> $past(host_wr && (host_cmd != 4'd0)));

  // R6: a timed stop is only pending while a train runs
  a_r6_stop_needs_train: assert property (@(posedge clk) disable iff (rst)
    stop_armed |-> train_on);

  // R12: a start is only pending while the output is idle
  a_r12_start_idle: assert property (@(posedge clk) disable iff (rst)
    start_armed |-> !(single_on || train_on));

  // R11: reset clears output, interrupt, field and flag
  a_r11_reset: assert property (@(posedge clk)
    rst |=> (!pps_out && !tgt_irq && (host_cmd == 4'd0) && !host_err));
endmodule

bind pps_cmd_gen pps_cmd_gen_chk #(.SEC_W(SEC_W), .NS_W(NS_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sys_sec     (sys_sec),
  .sys_ns      (sys_ns),
  .tgt_sec     (tgt_sec),
  .tgt_ns      (tgt_ns),
  .tgt_mode    (tgt_mode),
  .host_wr     (host_wr),
  .host_cmd    (host_cmd),
  .host_err    (host_err),
  .pps_out     (pps_out),
  .tgt_irq     (tgt_irq),
  .start_armed (start_armed),
  .stop_armed  (stop_armed),
  .single_on   (single_on),
  .train_on    (train_on)
);

// File: tb/tb_pps_cmd_gen.sv
module tb_pps_cmd_gen;
  localparam int SW = 4;
  localparam int NW = 4;
  localparam int WW = 4;
  localparam int TW = SW + NW;
  localparam int NEVER = 1000;

  logic          clk = 1'b0;
  logic          rst;
  logic [TW-1:0] now_t, due_t;
  logic [WW-1:0] pulse_width;
  logic [1:0]    tgt_mode;
  logic          host_wr;
  logic [3:0]    host_wdata;
  logic [3:0]    host_cmd;
  logic          host_err, pps_out, tgt_irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;   // 50 MHz

  pps_cmd_gen #(.SEC_W(SW), .NS_W(NW), .WID_W(WW)) dut (
    .clk         (clk),
    .rst         (rst),
    .sys_sec     (now_t[TW-1:NW]),
    .sys_ns      (now_t[NW-1:0]),
    .tgt_sec     (due_t[TW-1:NW]),
    .tgt_ns      (due_t[NW-1:0]),
    .pulse_width (pulse_width),
    .tgt_mode    (tgt_mode),
    .host_wr     (host_wr),
    .host_wdata  (host_wdata),
    .host_cmd    (host_cmd),
    .host_err    (host_err),
    .pps_out     (pps_out),
    .tgt_irq     (tgt_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; host_wr = 1'b0; host_wdata = 4'd0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R11 reset pps", int'(pps_out), 0);
    chk("R11 reset irq", int'(tgt_irq), 0);
    chk("R11 reset cmd", int'(host_cmd), 0);
    chk("R11 reset err", int'(host_err), 0);
  endtask

  // One scenario: up to three command writes, optional reset, per-cycle compare.
  // Sample c reflects the clock edge at which the time input equals base + c.
  task automatic run(input string tag, input int mode, input int w, input int base,
                     input int code0, input int t0,
                     input int c1_at, input int code1, input int t1,
                     input int c2_at, input int code2, input int rst_at,
                     input int ncyc, input int e_start, input int e_kind,
                     input int e_stop, input int irq_a, input int irq_b,
                     input int e_err);
    int eff;
    eff = (w == 0) ? 1 : w;
    do_reset();
    for (int c = 0; c < ncyc; c++) begin
      int ep, ei;
      now_t       = TW'(base + c);
      due_t       = (c1_at >= 0 && c >= c1_at) ? TW'(base + t1) : TW'(base + t0);
      pulse_width = WW'(w);
      tgt_mode    = 2'(mode);
      rst         = (c == rst_at);
      host_wr     = 1'b0;
      host_wdata  = 4'd0;
      if (c == 0 && code0 != 0) begin host_wr = 1'b1; host_wdata = 4'(code0); end
      if (c == c1_at && code1 != 0) begin host_wr = 1'b1; host_wdata = 4'(code1); end
      if (c == c2_at && code2 != 0) begin host_wr = 1'b1; host_wdata = 4'(code2); end
      @(posedge clk);
      @(negedge clk);
      host_wr = 1'b0;
      rst     = 1'b0;
      ep = 0;
      if (e_start >= 0 && c >= e_start && c < e_stop) begin
        if (e_kind == 1) ep = (c < e_start + eff) ? 1 : 0;
        else             ep = (((c - e_start) / eff) % 2 == 0) ? 1 : 0;
      end
      ei = (c == irq_a || c == irq_b) ? 1 : 0;
      chk({tag, " pps"}, int'(pps_out), ep);
      chk({tag, " irq"}, int'(tgt_irq), ei);
      if (c == 0 && c != rst_at) chk("R8 field loaded", int'(host_cmd), code0);
      if (c == 1 && code0 != 0 && rst_at != 0) chk("R8 field cleared", int'(host_cmd), 0);
    end
    chk({tag, " R9 err flag"}, int'(host_err), e_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; host_wr = 1'b0; host_wdata = 4'd0;
    now_t = '0; due_t = '0; pulse_width = '0; tgt_mode = 2'd0;

    // R2 R3 R4 R10: start sweep over mode, kind, width, target, time base
    for (int mode = 0; mode < 4; mode++)
      for (int kind = 1; kind <= 2; kind++)
        for (int w = 0; w < 4; w++)
          for (int ti = 0; ti < 3; ti++)
            for (int bi = 0; bi < 2; bi++) begin
              int t, base, es, ia;
              t    = (ti == 0) ? 2 : (ti == 1) ? 3 : 5;
              base = (bi == 0) ? 0 : 14;   // base 14 puts the target across ns rollover
              es   = ((mode >> 1) & 1) ? t : -1;
              ia   = ((mode & 1) == 0) ? t : -1;
              run(kind == 1 ? "R2 R4 R10 single" : "R3 R4 R10 train",
                  mode, w, base, kind, t, -1, 0, 0, -1, 0, -1,
                  16, es, kind, NEVER, ia, -1, 0);
            end

    // R1: reserved and empty codes change nothing
    for (int code = 7; code < 16; code++)
      run("R1 reserved", 2, 2, 0, code, 2, -1, 0, 0, -1, 0, -1, 8, -1, 1, NEVER, -1, -1, 0);
    run("R1 none", 2, 2, 0, 0, 2, -1, 0, 0, -1, 0, -1, 8, -1, 1, NEVER, -1, -1, 0);

    // R5: cancel start before and after the target
    run("R5 cancel early single", 3, 2, 14, 1, 8, 2, 3, 8, -1, 0, -1, 14, -1, 1, NEVER, -1, -1, 0);
    run("R5 cancel early train", 2, 2, 14, 2, 8, 2, 3, 8, -1, 0, -1, 14, -1, 2, NEVER, -1, -1, 0);
    run("R5 cancel late", 3, 3, 14, 1, 2, 3, 3, 2, -1, 0, -1, 12, 2, 1, NEVER, -1, -1, 0);

    // R6: timed stop sweep, interrupt on both start and stop in mode 2
    for (int w = 1; w < 4; w++)
      for (int s = 9; s < 13; s++)
        run("R6 timed stop", 2, w, 0, 2, 2, 6, 4, s, -1, 0, -1, 18, 2, 2, s, 2, s, 0);
    run("R6 stop now", 3, 2, 0, 2, 2, 7, 5, 2, -1, 0, -1, 16, 2, 2, 8, -1, -1, 0);
    run("R6 stop now single", 3, 6, 0, 1, 2, 4, 5, 2, -1, 0, -1, 12, 2, 1, NEVER, -1, -1, 0);
    run("R6 stop at single", 3, 6, 0, 1, 2, 4, 4, 6, -1, 0, -1, 12, 2, 1, NEVER, -1, -1, 0);

    // R7: cancel stop before and after its target
    run("R7 cancel stop early", 3, 2, 0, 2, 2, 5, 4, 12, 7, 6, -1, 20, 2, 2, NEVER, -1, -1, 0);
    run("R7 cancel stop late", 3, 2, 0, 2, 2, 5, 4, 9, 10, 6, -1, 16, 2, 2, 9, -1, -1, 0);

    // R12: start into a running train is ignored
    run("R12 start while busy", 3, 2, 0, 2, 2, 6, 1, 2, -1, 0, -1, 16, 2, 2, NEVER, -1, -1, 0);

    // R9: back-to-back write is dropped (its cancel would have removed the train)
    run("R9 dropped write", 3, 2, 0, 2, 4, 1, 3, 4, -1, 0, -1, 12, 4, 2, NEVER, -1, -1, 1);

    // R11: reset while a start is pending and while a train runs
    run("R11 reset pending", 2, 2, 0, 1, 6, -1, 0, 0, -1, 0, 3, 12, -1, 1, NEVER, -1, -1, 0);
    run("R11 reset train", 3, 2, 0, 2, 2, -1, 0, 0, -1, 0, 6, 14, 2, 2, 6, -1, -1, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule